// File: doc/BRIEF.md
# I2C Target Controller with Per-Byte Clock Stretching

This block is an I2C target (slave) on an open-drain two-wire bus. It runs on a fast system clock. The raw SCL and SDA pins are synchronized and their edges are detected on that clock. The block recognizes START, repeated START and STOP conditions and compares the 7-bit address that follows a START with a configurable own address. On a match it acknowledges and then either receives data bytes from the bus controller or sends bytes to it. The direction bit of the address byte selects which.

After every acknowledged byte the target pulls SCL low and raises an interrupt. The bus then waits for the host-side logic. On a write, the host reads the received byte and acknowledges the interrupt. On a read, the host loads the next byte to send and acknowledges the interrupt. SCL is released only once both of these are done. The block never drives a line high. Each bus output is an enable that pulls its line low when set.

The system clock must run at least 8 times faster than SCL.

Top module: `i2c_tgt_stretch`

## Requirements
- R1: After reset, scl_oe_o, sda_oe_o, irq_o, rx_valid_o and stop_seen_o are all 0, so both bus lines are released.
- R2: A START or repeated START begins an address phase. In that phase 8 bits are taken MSB first: the 7-bit address, then a direction bit (0 = write to the target, 1 = read from it). If the address equals own_addr_i, sda_oe_o is 1 throughout the ninth clock, so the bus reads SDA = 0 there.
- R3: If the address does not match, the target does not acknowledge (SDA reads 1 on the ninth clock). It also raises no interrupt and does not pull SCL low. It ignores all further bus activity until the next START.
- R4: On a write, each data byte is shifted in MSB first. It appears on rx_data_o with rx_valid_o = 1 from the eighth rising SCL edge, and the target acknowledges it on the ninth clock.
- R5: Once the ninth clock of an acknowledged byte ends, the target holds SCL low and sets irq_o. This applies to the address byte, to a written byte and to a read byte that the bus controller acknowledged. The target keeps SCL low at least until irq_ack_i is pulsed. irq_ack_i clears irq_o and rx_valid_o.
- R6: On a read, the target sends the loaded byte MSB first. It changes sda_oe_o only in the cycles that follow a falling SCL edge. A 0 bit is sent by pulling SDA low. If the bus controller acknowledges (SDA = 0 on the ninth clock), the target stretches again. If it does not acknowledge (SDA = 1), the target releases both lines and goes idle.
- R7: When a read needs a byte, SCL stays low until tx_load_i has been pulsed, even if the interrupt was already acknowledged. If tx_load_i and irq_ack_i arrive in the same cycle, SCL is released and the tx_data_i value of that cycle is sent.
- R8: A STOP seen after an address match sets stop_seen_o. The flag stays set until an irq_ack_i pulse clears it.
- R9: A START or STOP that arrives in the middle of a byte abandons that byte, releases both lines and produces no rx_valid_o. After a START, the next 8 bits are taken as a new address byte.
- R10: The bus outputs are pull-low enables only: a 1 pulls the line low and a 0 releases it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | System clock, at least 8x SCL |
| rst_ni | input | 1 | Asynchronous reset, active low |
| scl_i | input | 1 | Sensed SCL line level |
| sda_i | input | 1 | Sensed SDA line level |
| scl_oe_o | output | 1 | Pull SCL low when 1 |
| sda_oe_o | output | 1 | Pull SDA low when 1 |
| own_addr_i | input | 7 | Target address to match |
| rx_data_o | output | 8 | Last byte received on a write |
| rx_valid_o | output | 1 | rx_data_o holds an unread byte |
| tx_data_i | input | 8 | Next byte to send on a read |
| tx_load_i | input | 1 | Pulse: capture tx_data_i |
| irq_o | output | 1 | Byte-done interrupt |
| irq_ack_i | input | 1 | Pulse: clear irq_o, rx_valid_o, stop_seen_o |
| stop_seen_o | output | 1 | STOP seen since the last acknowledge, while addressed |

## Verification
The acknowledge of the interrupt and the load of the next read byte can fall in the same cycle while SCL is being stretched. In that case the release decision has to take the byte straight from tx_data_i. The host model issues both strobes together on one read transfer, and issues the acknowledge well ahead of the load on another. The bench times how long the bus controller waits with SCL held low. The combined case must release the bus in less than one host delay. The split case must hold the bus for more than one and a half delays. In both cases the byte read back must equal the byte that was loaded.

// File: rtl/i2c_tgt_pkg.sv
package i2c_tgt_pkg;

  typedef enum logic [3:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_END,
    ST_AACK,
    ST_RX,
    ST_RX_END,
    ST_RACK,
    ST_HOLD,
    ST_TX,
    ST_TACK
  } tgt_state_e;

  typedef struct packed {
    logic scl_rise;
    logic scl_fall;
    logic sda;
    logic start;
    logic stop;
  } bus_ev_t;

endpackage

// File: rtl/i2c_tgt_sync.sv
module i2c_tgt_sync #(
  parameter int unsigned STAGES = 2,
  parameter int unsigned LINES  = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [LINES-1:0] raw_i,
  output logic [LINES-1:0] sync_o
);

  for (genvar g = 0; g < LINES; g++) begin : g_line
    logic [STAGES-1:0] ff_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) ff_q <= '1;  // idle bus is high
      else         ff_q <= {ff_q[STAGES-2:0], raw_i[g]};
    end
    assign sync_o[g] = ff_q[STAGES-1];
  end

endmodule

// File: rtl/i2c_tgt_cond.sv
module i2c_tgt_cond
  import i2c_tgt_pkg::*;
(
  input  logic    clk_i,
  input  logic    rst_ni,
  input  logic    scl_s_i,
  input  logic    sda_s_i,
  output bus_ev_t ev_o
);

  logic scl_q, sda_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s_i;
      sda_q <= sda_s_i;
    end
  end

  always_comb begin
    ev_o.scl_rise = scl_s_i & ~scl_q;
    ev_o.scl_fall = ~scl_s_i & scl_q;
    ev_o.sda      = sda_s_i;
    // SDA edge while SCL stays high
    ev_o.start    = scl_s_i & scl_q & sda_q & ~sda_s_i;
    ev_o.stop     = scl_s_i & scl_q & ~sda_q & sda_s_i;
  end

endmodule

// File: rtl/i2c_tgt_host.sv
module i2c_tgt_host #(
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          irq_ack_i,
  input  logic          tx_load_i,
  input  logic [DW-1:0] tx_data_i,
  input  logic          byte_done_i,
  input  logic          rx_push_i,
  input  logic [DW-1:0] rx_byte_i,
  input  logic          tx_take_i,
  input  logic          stop_hit_i,
  output logic          irq_o,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  output logic          stop_seen_o,
  output logic          tx_full_o,
  output logic [DW-1:0] tx_buf_o
);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_o       <= 1'b0;
      rx_data_o   <= '0;
      rx_valid_o  <= 1'b0;
      stop_seen_o <= 1'b0;
      tx_full_o   <= 1'b0;
      tx_buf_o    <= '0;
    end else begin
      if (byte_done_i)    irq_o <= 1'b1;
      else if (irq_ack_i) irq_o <= 1'b0;

      if (rx_push_i) begin
        rx_data_o  <= rx_byte_i;
        rx_valid_o <= 1'b1;
      end else if (irq_ack_i) begin
        rx_valid_o <= 1'b0;
      end

      if (stop_hit_i)     stop_seen_o <= 1'b1;
      else if (irq_ack_i) stop_seen_o <= 1'b0;

      if (tx_load_i) tx_buf_o <= tx_data_i;
      // a take in the load cycle consumes the bypassed byte
      if (tx_take_i)      tx_full_o <= 1'b0;
      else if (tx_load_i) tx_full_o <= 1'b1;
    end
  end

  a_r5_irq_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (irq_o && !irq_ack_i) |=> irq_o);

  a_r8_stop_flag: assert property (@(posedge clk_i) disable iff (!rst_ni)
    stop_hit_i |=> stop_seen_o);

endmodule

// File: rtl/i2c_tgt_fsm.sv
module i2c_tgt_fsm
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned AW = 7,
  parameter int unsigned DW = 8
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  bus_ev_t       ev_i,
  input  logic [AW-1:0] own_addr_i,
  input  logic          irq_pend_i,
  input  logic          irq_ack_i,
  input  logic          tx_full_i,
  input  logic          tx_load_i,
  input  logic [DW-1:0] tx_byte_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  output logic          byte_done_o,
  output logic          rx_push_o,
  output logic [DW-1:0] rx_byte_o,
  output logic          tx_take_o,
  output logic          stop_hit_o
);

  localparam int unsigned ABITS = AW + 1;
  localparam int unsigned SW    = (DW > ABITS) ? DW : ABITS;
  localparam int unsigned CW    = $clog2(SW);
  localparam logic [CW-1:0] A_LAST = CW'(ABITS - 1);
  localparam logic [CW-1:0] D_LAST = CW'(DW - 1);

  tgt_state_e    state_q;
  logic [CW-1:0] cnt_q;
  logic [SW-1:0] sh_q;
  logic          rd_q, sel_q, ack_q;
  logic          scl_oe_q, sda_oe_q;
  logic          bus_cond, release_ok;

  assign bus_cond   = ev_i.start | ev_i.stop;
  assign release_ok = (!irq_pend_i || irq_ack_i) && (!rd_q || tx_full_i || tx_load_i);

  always_comb begin
    byte_done_o = ev_i.scl_fall && !bus_cond &&
                  (state_q == ST_AACK || state_q == ST_RACK ||
                   (state_q == ST_TACK && ack_q));
    rx_push_o   = (state_q == ST_RX) && ev_i.scl_rise && (cnt_q == D_LAST) && !bus_cond;
    rx_byte_o   = {sh_q[DW-2:0], ev_i.sda};
    tx_take_o   = (state_q == ST_HOLD) && release_ok && rd_q && !bus_cond;
    stop_hit_o  = ev_i.stop && sel_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q  <= ST_IDLE;
      cnt_q    <= '0;
      sh_q     <= '0;
      rd_q     <= 1'b0;
      sel_q    <= 1'b0;
      ack_q    <= 1'b0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (ev_i.stop) begin
      state_q  <= ST_IDLE;
      sel_q    <= 1'b0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else if (ev_i.start) begin
      state_q  <= ST_ADDR;
      cnt_q    <= '0;
      sel_q    <= 1'b0;
      scl_oe_q <= 1'b0;
      sda_oe_q <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: ;
        ST_ADDR, ST_RX: begin
          if (ev_i.scl_rise) begin
            sh_q  <= {sh_q[SW-2:0], ev_i.sda};
            cnt_q <= cnt_q + CW'(1);
            if (state_q == ST_ADDR && cnt_q == A_LAST) state_q <= ST_ADDR_END;
            if (state_q == ST_RX && cnt_q == D_LAST)   state_q <= ST_RX_END;
          end
        end
        ST_ADDR_END: begin
          if (ev_i.scl_fall) begin
            if (sh_q[AW:1] == own_addr_i) begin
              sda_oe_q <= 1'b1;
              rd_q     <= sh_q[0];
              sel_q    <= 1'b1;
              state_q  <= ST_AACK;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
        end
        ST_RX_END: begin
          if (ev_i.scl_fall) begin
            sda_oe_q <= 1'b1;
            state_q  <= ST_RACK;
          end
        end
        ST_AACK, ST_RACK: begin
          if (ev_i.scl_fall) begin
            sda_oe_q <= 1'b0;
            scl_oe_q <= 1'b1;
            state_q  <= ST_HOLD;
          end
        end
        ST_HOLD: begin
          if (release_ok) begin
            scl_oe_q <= 1'b0;
            cnt_q    <= '0;
            if (rd_q) begin
              sh_q[DW-1:0] <= tx_byte_i;
              sda_oe_q     <= ~tx_byte_i[DW-1];
              state_q      <= ST_TX;
            end else begin
              state_q      <= ST_RX;
            end
          end
        end
        ST_TX: begin
          if (ev_i.scl_fall) begin
            cnt_q <= cnt_q + CW'(1);
            if (cnt_q == D_LAST) begin
              sda_oe_q <= 1'b0;
              state_q  <= ST_TACK;
            end else begin
              sh_q[DW-1:0] <= {sh_q[DW-2:0], 1'b0};
              sda_oe_q     <= ~sh_q[DW-2];
            end
          end
        end
        ST_TACK: begin
          if (ev_i.scl_rise) ack_q <= ~ev_i.sda;
          if (ev_i.scl_fall) begin
            if (ack_q) begin
              scl_oe_q <= 1'b1;
              state_q  <= ST_HOLD;
            end else begin
              state_q  <= ST_IDLE;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign scl_oe_o = scl_oe_q;
  assign sda_oe_o = sda_oe_q;

  a_r2_ack_driven: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_AACK) |-> sda_oe_q);

  a_r3_idle_released: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_IDLE) |-> (!scl_oe_q && !sda_oe_q));

  a_r5_stretch_cause: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scl_oe_q |-> (irq_pend_i || !tx_full_i));

  a_r6_sda_after_fall: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_TX && $past(state_q) == ST_TX && !$past(ev_i.scl_fall))
      |-> $stable(sda_oe_q));

  a_r8_stop_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ev_i.stop |=> (state_q == ST_IDLE && !scl_oe_q && !sda_oe_q));

  a_r9_start_addr: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ev_i.start && !ev_i.stop) |=> (state_q == ST_ADDR && cnt_q == '0));

endmodule

// File: rtl/i2c_tgt_stretch.sv
module i2c_tgt_stretch
  import i2c_tgt_pkg::*;
#(
  parameter int unsigned AW          = 7,
  parameter int unsigned DW          = 8,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          scl_i,
  input  logic          sda_i,
  output logic          scl_oe_o,
  output logic          sda_oe_o,
  input  logic [AW-1:0] own_addr_i,
  output logic [DW-1:0] rx_data_o,
  output logic          rx_valid_o,
  input  logic [DW-1:0] tx_data_i,
  input  logic          tx_load_i,
  output logic          irq_o,
  input  logic          irq_ack_i,
  output logic          stop_seen_o
);

  logic [1:0]    lines_s;
  bus_ev_t       ev;
  logic          byte_done, rx_push, tx_take, stop_hit, tx_full;
  logic [DW-1:0] rx_byte, tx_buf, tx_byte;

  i2c_tgt_sync #(.STAGES(SYNC_STAGES), .LINES(2)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({scl_i, sda_i}),
    .sync_o (lines_s)
  );

  i2c_tgt_cond u_cond (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .scl_s_i (lines_s[1]),
    .sda_s_i (lines_s[0]),
    .ev_o    (ev)
  );

  // a load in the release cycle goes straight to the shifter
  assign tx_byte = tx_load_i ? tx_data_i : tx_buf;

  i2c_tgt_fsm #(.AW(AW), .DW(DW)) u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .ev_i        (ev),
    .own_addr_i  (own_addr_i),
    .irq_pend_i  (irq_o),
    .irq_ack_i   (irq_ack_i),
    .tx_full_i   (tx_full),
    .tx_load_i   (tx_load_i),
    .tx_byte_i   (tx_byte),
    .scl_oe_o    (scl_oe_o),
    .sda_oe_o    (sda_oe_o),
    .byte_done_o (byte_done),
    .rx_push_o   (rx_push),
    .rx_byte_o   (rx_byte),
    .tx_take_o   (tx_take),
    .stop_hit_o  (stop_hit)
  );

  i2c_tgt_host #(.DW(DW)) u_host (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .irq_ack_i   (irq_ack_i),
    .tx_load_i   (tx_load_i),
    .tx_data_i   (tx_data_i),
    .byte_done_i (byte_done),
    .rx_push_i   (rx_push),
    .rx_byte_i   (rx_byte),
    .tx_take_i   (tx_take),
    .stop_hit_i  (stop_hit),
    .irq_o       (irq_o),
    .rx_data_o   (rx_data_o),
    .rx_valid_o  (rx_valid_o),
    .stop_seen_o (stop_seen_o),
    .tx_full_o   (tx_full),
    .tx_buf_o    (tx_buf)
  );

endmodule

// File: tb/sim_i2c_tgt_stretch.sv
module sim_i2c_tgt_stretch;

  localparam int Q  = 8;   // quarter SCL period in clk cycles
  localparam int HD = 60;  // host service delay
  localparam logic [6:0] OWN = 7'h2A;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  always #10 clk = ~clk;

  logic scl_m = 1'b1, sda_m = 1'b1;
  logic scl_oe_o, sda_oe_o, rx_valid_o, irq_o, stop_seen_o;
  logic [7:0] rx_data_o;
  logic [7:0] tx_data_i = '0;
  logic tx_load_i = 1'b0, irq_ack_i = 1'b0;
  wire scl_bus = scl_m & ~scl_oe_o;
  wire sda_bus = sda_m & ~sda_oe_o;

  i2c_tgt_stretch u0 (
    .clk_i(clk), .rst_ni(rst_ni), .scl_i(scl_bus), .sda_i(sda_bus),
    .scl_oe_o(scl_oe_o), .sda_oe_o(sda_oe_o), .own_addr_i(OWN),
    .rx_data_o(rx_data_o), .rx_valid_o(rx_valid_o), .tx_data_i(tx_data_i),
    .tx_load_i(tx_load_i), .irq_o(irq_o), .irq_ack_i(irq_ack_i),
    .stop_seen_o(stop_seen_o)
  );

  int n_chk = 0, n_fail = 0;
  int irq_cnt = 0;
  bit host_rd = 0, split = 0, clr_req = 0, done = 0, scl_seen = 0;
  int first_st;
  logic [7:0] exp_q[$];
  logic [7:0] tx_q[$];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // host model
  initial begin
    forever begin
      @(negedge clk);
      if (irq_o) begin
        irq_cnt++;
        repeat (HD) @(negedge clk);
        if (host_rd && tx_q.size() > 0) begin
          if (split) begin
            irq_ack_i = 1'b1; @(negedge clk); irq_ack_i = 1'b0;
            repeat (HD) @(negedge clk);
            tx_data_i = tx_q.pop_front(); tx_load_i = 1'b1;
            @(negedge clk); tx_load_i = 1'b0;
          end else begin
            tx_data_i = tx_q.pop_front(); tx_load_i = 1'b1; irq_ack_i = 1'b1;
            @(negedge clk); tx_load_i = 1'b0; irq_ack_i = 1'b0;
          end
        end else begin
          irq_ack_i = 1'b1; @(negedge clk); irq_ack_i = 1'b0;
        end
      end else if (clr_req) begin
        irq_ack_i = 1'b1; @(negedge clk); irq_ack_i = 1'b0;
        clr_req = 1'b0;
      end
    end
  end

  // scoreboard monitor for received bytes
  initial begin
    bit rv_prev = 0;
    logic [7:0] e;
    forever begin
      @(negedge clk);
      if (scl_oe_o) scl_seen = 1;
      if (rx_valid_o && !rv_prev) begin
        if (exp_q.size() == 0) chk(0, "R4 unexpected rx byte", rx_data_o, 0);
        else begin
          e = exp_q.pop_front();
          chk(rx_data_o == e, "R4 rx byte", rx_data_o, e);
        end
      end
      rv_prev = rx_valid_o;
    end
  end

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic raise_scl(output int st);
    scl_m = 1'b1; st = 0;
    while (!scl_bus && st < 20000) begin @(negedge clk); st++; end
  endtask

  task automatic put_bit(input bit b, output int st);
    sda_m = b; wq(Q);
    raise_scl(st);
    wq(2*Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic get_bit(output bit b, output int st);
    sda_m = 1'b1; wq(Q);
    raise_scl(st);
    wq(Q); b = sda_bus; wq(Q); scl_m = 1'b0; wq(Q);
  endtask

  task automatic send_byte(input logic [7:0] d, output bit acked);
    int st; bit b;
    for (int i = 7; i >= 0; i--) begin
      put_bit(d[i], st);
      if (i == 7) first_st = st;
    end
    get_bit(b, st);
    acked = !b;
  endtask

  task automatic recv_byte(input bit ack_m, output logic [7:0] d);
    int st; bit b;
    for (int i = 7; i >= 0; i--) begin
      get_bit(b, st);
      d[i] = b;
      if (i == 7) first_st = st;
    end
    put_bit(!ack_m, st);
  endtask

  task automatic do_start();
    int st;
    sda_m = 1'b1; wq(Q);
    raise_scl(st); wq(Q);
    sda_m = 1'b0; wq(Q);
    scl_m = 1'b0; wq(Q);
  endtask

  task automatic do_stop();
    int st;
    sda_m = 1'b0; wq(Q);
    raise_scl(st); wq(Q);
    sda_m = 1'b1; wq(Q);
  endtask

  task automatic clear_flags();
    clr_req = 1'b1;
    wait (clr_req == 1'b0);
    wq(4);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog expired for all requirements: actual=hung expected=done");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit ack;
    int ic;
    int st;
    logic [7:0] d;

    wq(5);
    rst_ni = 1'b1;
    wq(5);
    // R1 reset state, R10 lines released
    chk(!scl_oe_o && !sda_oe_o, "R1 R10 oe released after reset", {scl_oe_o, sda_oe_o}, 0);
    chk(!irq_o && !rx_valid_o && !stop_seen_o, "R1 flags clear after reset",
        {irq_o, rx_valid_o, stop_seen_o}, 0);

    // write transfer
    host_rd = 0;
    exp_q.push_back(8'hA5); exp_q.push_back(8'h3C);
    do_start();
    send_byte({OWN, 1'b0}, ack);
    chk(ack, "R2 address ack on ninth clock", ack, 1);
    send_byte(8'hA5, ack);
    chk(ack, "R4 data ack", ack, 1);
    chk(first_st >= HD/2 && first_st < HD, "R5 stretch after address byte", first_st, HD);
    send_byte(8'h3C, ack);
    chk(ack, "R4 data ack second", ack, 1);
    chk(first_st >= HD/2, "R5 stretch after data byte", first_st, HD);
    do_stop();
    wq(10);
    chk(irq_cnt == 3, "R5 one interrupt per acknowledged byte", irq_cnt, 3);
    chk(stop_seen_o, "R8 stop seen after addressed transfer", stop_seen_o, 1);
    chk(exp_q.size() == 0, "R4 all bytes received", exp_q.size(), 0);
    chk(!rx_valid_o, "R5 rx_valid cleared by irq_ack", rx_valid_o, 0);
    clear_flags();
    chk(!stop_seen_o, "R8 stop_seen cleared by irq_ack", stop_seen_o, 0);

    // mismatched address
    ic = irq_cnt; scl_seen = 0;
    do_start();
    send_byte({7'h13, 1'b0}, ack);
    chk(!ack, "R3 no ack on mismatch", ack, 0);
    send_byte(8'hFF, ack);
    chk(!ack, "R3 later byte ignored", ack, 0);
    do_stop();
    wq(10);
    chk(irq_cnt == ic, "R3 no interrupt on mismatch", irq_cnt, ic);
    chk(!scl_seen, "R3 no stretch on mismatch", scl_seen, 0);
    chk(!stop_seen_o, "R8 stop ignored when not addressed", stop_seen_o, 0);

    // read, ack and load in the same cycle
    host_rd = 1; split = 0;
    tx_q.push_back(8'h96); tx_q.push_back(8'h5E);
    do_start();
    send_byte({OWN, 1'b1}, ack);
    chk(ack, "R2 read address ack", ack, 1);
    recv_byte(1'b1, d);
    chk(d == 8'h96, "R6 first read byte MSB first", d, 8'h96);
    chk(first_st >= HD/2 && first_st < HD, "R7 same-cycle ack and load release", first_st, HD);
    recv_byte(1'b0, d);
    chk(d == 8'h5E, "R6 second read byte", d, 8'h5E);
    chk(!sda_oe_o && !scl_oe_o, "R6 release after nack", {scl_oe_o, sda_oe_o}, 0);
    do_stop();
    wq(10);
    chk(stop_seen_o, "R8 stop after read", stop_seen_o, 1);
    clear_flags();

    // read, ack long before load
    split = 1;
    tx_q.push_back(8'h71);
    do_start();
    send_byte({OWN, 1'b1}, ack);
    recv_byte(1'b0, d);
    chk(first_st >= HD + HD/2, "R7 stretch held until load", first_st, HD + HD/2);
    chk(d == 8'h71, "R7 late-loaded byte sent", d, 8'h71);
    do_stop();
    wq(10);
    split = 0; host_rd = 0;
    clear_flags();

    // STOP in mid-byte
    do_start();
    send_byte({OWN, 1'b0}, ack);
    put_bit(1'b1, st); put_bit(1'b0, st); put_bit(1'b1, st);
    do_stop();
    wq(10);
    chk(!sda_oe_o && !scl_oe_o, "R9 lines released on mid-byte stop", {scl_oe_o, sda_oe_o}, 0);
    chk(!rx_valid_o, "R9 no rx byte from partial byte", rx_valid_o, 0);
    clear_flags();

    // repeated START in mid-byte
    exp_q.push_back(8'h0F);
    do_start();
    send_byte({OWN, 1'b0}, ack);
    put_bit(1'b0, st); put_bit(1'b1, st); put_bit(1'b1, st);
    do_start();
    send_byte({OWN, 1'b0}, ack);
    chk(ack, "R9 address phase restarted", ack, 1);
    send_byte(8'h0F, ack);
    do_stop();
    wq(10);
    chk(exp_q.size() == 0, "R9 byte after restart received", exp_q.size(), 0);
    clear_flags();

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

endmodule